// File: doc/BRIEF.md
# Nonvolatile Configuration Download Controller

This block fills the configuration register RAM of a supervisory chip from a paged nonvolatile array. Once the power-good input is seen high after reset, it copies the mirrored pages of the array into RAM one byte at a time. Software can repeat the same copy later by writing a self-clearing download bit. While any copy is running, and until a fixed boot cycle budget has passed after power-good, the block raises a busy output and ignores every host access.

The array is 16 pages of 32 bytes starting at address 0xF800. Only pages 0 through 6 (offsets 0x000 to 0x0DF) are mirrored. Page 7 is reserved and pages 8 to 15 are user storage, so neither is ever copied. The RAM address of a mirrored byte is its array address with the 0xF8 high byte removed. The copy always starts at the lowest address and moves upward.

Host writes that land in the array go through a blank check. The target byte is read first and is written only if it still holds the erased value 0xFF. A write to a non-blank byte is rejected and sets a sticky error flag. A saturating counter records how many array writes were accepted.

Top module: `nvcfg_loader`

## Requirements
- R1: During and after reset, with power-good low: bus_busy is 1; nv_rd_en, nv_wr_en, ram_wr_en and load_done are 0; wr_count is 0. No array read is issued until power-good is sampled high.
- R2: Once power-good is sampled high, the block copies array offsets 0x000 to 0x0DF (pages 0–6 of 32 bytes, base 0xF800) to RAM. Each RAM address equals the array address minus 0xF800. No RAM write is made for page 7 or pages 8–15.
- R3: bus_busy stays 1 until two conditions hold: the power-up copy has finished, and BOOT_CYCLES clock edges have passed, counting the edge that sampled power-good as the first.
- R4: When not busy, a host write to address 0x00D8 with data bit 0 = 1 starts a fresh copy of the same pages. A write there with bit 0 = 0 starts nothing.
- R5: While bus_busy is 1, host reads and writes are ignored. No array write is made, no copy is started, host_rdata is unchanged and the error flag is not cleared. This includes a download request held through the final cycle of a copy.
- R6: Copied bytes are written to RAM in ascending address order, one byte every RD_LAT+1 cycles. nv_rd_data is sampled RD_LAT clock edges after the edge that takes nv_rd_en.
- R7: load_done pulses for one cycle, together with the RAM write of the last mirrored byte (RAM address 0xDF). The download bit then clears, so a read of 0x00D8 returns 0.
- R8: A host write to an address in 0xF800–0xF9FF first reads that byte. The byte is written (nv_wr_en, same address and data) only if it reads 0xFF. Otherwise no write is made.
- R9: A rejected array write sets an error flag, which reads back as bit 0 at address 0x00D9. A read of that address returns the flag and clears it. host_rdata holds a read's result from the cycle after the read.
- R10: wr_count rises by one for each accepted array write and stops at its all-ones value.
- R11: A host write to any address outside the array and the download register has no effect: no array write, no copy, bus_busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwr_good | input | 1 | Supply valid |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, one cycle after the read |
| bus_busy | output | 1 | Host accesses refused |
| nv_rd_en | output | 1 | Array read request |
| nv_rd_addr | output | ADDR_W | Array read address |
| nv_rd_data | input | DATA_W | Array read data, RD_LAT edges after the request |
| nv_wr_en | output | 1 | Array byte write strobe |
| nv_wr_addr | output | ADDR_W | Array write address |
| nv_wr_data | output | DATA_W | Array write data |
| ram_wr_en | output | 1 | Register RAM write strobe |
| ram_wr_addr | output | RAM_AW | Register RAM address |
| ram_wr_data | output | DATA_W | Register RAM data |
| load_done | output | 1 | One-cycle end-of-copy pulse |
| wr_count | output | CNT_W | Saturating count of accepted array writes |

## Verification
The collision that matters is a download request arriving in the same cycle as the final byte capture of a running copy. That request must be dropped: the copy's end must not re-arm it. The bench provokes this by holding a download write on the host port for the whole of a user copy, including its last capture edge, and letting go only when load_done is seen. The reference model expects exactly one set of 224 RAM writes. Any extra write arriving after the expected queue is empty is reported.

// File: rtl/nvcfg_pkg.sv
package nvcfg_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,  // waiting for supply valid
        ST_CP_RD = 3'd1,  // copy: issue array read
        ST_CP_WT = 3'd2,  // copy: wait read latency, then move byte
        ST_IDLE  = 3'd3,  // accepting host accesses (after boot budget)
        ST_WR_RD = 3'd4,  // host array write: blank-check read
        ST_WR_WT = 3'd5   // host array write: wait, then commit or reject
    } ldr_state_e;

endpackage

// File: rtl/nvcfg_addr_map.sv
module nvcfg_addr_map #(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned BASE        = 'hF800,
    parameter int unsigned ARRAY_BYTES = 512,
    parameter int unsigned IDX_W       = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_array,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W:0] off;

    always_comb begin
        off      = {1'b0, addr} - (ADDR_W+1)'(BASE);
        in_array = !off[ADDR_W] && (off < (ADDR_W+1)'(ARRAY_BYTES));
        idx      = IDX_W'(off);
    end
endmodule

// File: rtl/nvcfg_boot_gate.sv
module nvcfg_boot_gate #(
    parameter int unsigned BOOT_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ready
);
    localparam int unsigned CW = $clog2(BOOT_CYCLES + 1);

    generate
        if (BOOT_CYCLES < 2) begin : g_none
            assign ready = run;
        end else begin : g_count
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (run && !ready) cnt_d = cnt_q + CW'(1);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign ready = (cnt_q == CW'(BOOT_CYCLES - 1));
        end
    endgenerate
endmodule

// File: rtl/nvcfg_wear_counter.sv
module nvcfg_wear_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != '1)) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/nvcfg_loader.sv
module nvcfg_loader
    import nvcfg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned RAM_AW      = 8,
    parameter int unsigned BASE        = 'hF800,
    parameter int unsigned PAGE_BYTES  = 32,
    parameter int unsigned NUM_PAGES   = 16,
    parameter int unsigned COPY_PAGES  = 7,
    parameter int unsigned RD_LAT      = 2,
    parameter int unsigned BOOT_CYCLES = 200000,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned CTRL_ADDR   = 'h00D8,
    parameter int unsigned STAT_ADDR   = 'h00D9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              host_wr_en,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              bus_busy,
    output logic              nv_rd_en,
    output logic [ADDR_W-1:0] nv_rd_addr,
    input  logic [DATA_W-1:0] nv_rd_data,
    output logic              nv_wr_en,
    output logic [ADDR_W-1:0] nv_wr_addr,
    output logic [DATA_W-1:0] nv_wr_data,
    output logic              ram_wr_en,
    output logic [RAM_AW-1:0] ram_wr_addr,
    output logic [DATA_W-1:0] ram_wr_data,
    output logic              load_done,
    output logic [CNT_W-1:0]  wr_count
);
    localparam int unsigned ARRAY_BYTES = PAGE_BYTES * NUM_PAGES;
    localparam int unsigned COPY_BYTES  = PAGE_BYTES * COPY_PAGES;
    localparam int unsigned IDX_W       = $clog2(ARRAY_BYTES);
    localparam int unsigned LAT_W       = $clog2(RD_LAT + 1);

    typedef struct packed {
        ldr_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [LAT_W-1:0]  lat;
        logic              dl;
        logic              err;
        logic              ram_we;
        logic [RAM_AW-1:0] ram_addr;
        logic [DATA_W-1:0] ram_data;
        logic              nv_we;
        logic [DATA_W-1:0] nv_data;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } ldr_regs_t;

    ldr_regs_t d, q;

    logic             boot_ready;
    logic             host_in_array;
    logic [IDX_W-1:0] host_idx;
    logic             access_ok;
    logic             ctrl_hit;
    logic             stat_hit;

    nvcfg_addr_map #(
        .ADDR_W     (ADDR_W),
        .BASE       (BASE),
        .ARRAY_BYTES(ARRAY_BYTES),
        .IDX_W      (IDX_W)
    ) i_addr_map (
        .addr    (host_addr),
        .in_array(host_in_array),
        .idx     (host_idx)
    );

    nvcfg_boot_gate #(
        .BOOT_CYCLES(BOOT_CYCLES)
    ) i_boot_gate (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.st != ST_OFF),
        .ready(boot_ready)
    );

    nvcfg_wear_counter #(
        .CNT_W(CNT_W)
    ) i_wear_counter (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (q.nv_we),
        .count(wr_count)
    );

    assign bus_busy  = (q.st != ST_IDLE) || !boot_ready;
    assign access_ok = !bus_busy;
    assign ctrl_hit  = (host_addr == ADDR_W'(CTRL_ADDR));
    assign stat_hit  = (host_addr == ADDR_W'(STAT_ADDR));

    always_comb begin
        d        = q;
        d.ram_we = 1'b0;
        d.nv_we  = 1'b0;
        d.done   = 1'b0;

        // Host register reads (only when not busy)
        if (host_rd_en && access_ok) begin
            if (ctrl_hit) begin
                d.rdata = {{(DATA_W-1){1'b0}}, q.dl};
            end else if (stat_hit) begin
                d.rdata = {{(DATA_W-1){1'b0}}, q.err};
                d.err   = 1'b0;
            end else begin
                d.rdata = '0;
            end
        end

        unique case (q.st)
            ST_OFF: begin
                if (pwr_good) begin
                    d.st  = ST_CP_RD;
                    d.idx = '0;
                end
            end
            ST_CP_RD: begin
                d.st  = ST_CP_WT;
                d.lat = LAT_W'(RD_LAT - 1);
            end
            ST_CP_WT: begin
                if (q.lat != '0) begin
                    d.lat = q.lat - LAT_W'(1);
                end else begin
                    d.ram_we   = 1'b1;
                    d.ram_addr = RAM_AW'(q.idx);
                    d.ram_data = nv_rd_data;
                    if (q.idx == IDX_W'(COPY_BYTES - 1)) begin
                        d.st   = ST_IDLE;
                        d.dl   = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                        d.st  = ST_CP_RD;
                    end
                end
            end
            ST_IDLE: begin
                if (host_wr_en && access_ok) begin
                    if (ctrl_hit) begin
                        if (host_wdata[0]) begin
                            d.dl  = 1'b1;
                            d.idx = '0;
                            d.st  = ST_CP_RD;
                        end
                    end else if (host_in_array) begin
                        d.idx     = host_idx;
                        d.nv_data = host_wdata;
                        d.st      = ST_WR_RD;
                    end
                end
            end
            ST_WR_RD: begin
                d.st  = ST_WR_WT;
                d.lat = LAT_W'(RD_LAT - 1);
            end
            ST_WR_WT: begin
                if (q.lat != '0) begin
                    d.lat = q.lat - LAT_W'(1);
                end else begin
                    if (nv_rd_data == '1) d.nv_we = 1'b1;
                    else                  d.err   = 1'b1;
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_OFF, default: '0};
        end else begin
            q <= d;
        end
    end

    assign nv_rd_en    = (q.st == ST_CP_RD) || (q.st == ST_WR_RD);
    assign nv_rd_addr  = ADDR_W'(BASE) + ADDR_W'(q.idx);
    assign nv_wr_en    = q.nv_we;
    assign nv_wr_addr  = ADDR_W'(BASE) + ADDR_W'(q.idx);
    assign nv_wr_data  = q.nv_data;
    assign ram_wr_en   = q.ram_we;
    assign ram_wr_addr = q.ram_addr;
    assign ram_wr_data = q.ram_data;
    assign load_done   = q.done;
    assign host_rdata  = q.rdata;

endmodule

// File: rtl/nvcfg_loader_chk.sv
module nvcfg_loader_chk #(
    parameter int unsigned RAM_AW     = 8,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned COPY_BYTES = 224
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_busy,
    input logic [DATA_W-1:0] nv_rd_data,
    input logic              nv_wr_en,
    input logic              ram_wr_en,
    input logic [RAM_AW-1:0] ram_wr_addr,
    input logic              load_done,
    input logic [CNT_W-1:0]  wr_count
);
    logic [RAM_AW-1:0] last_addr;
    logic              seen_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_addr <= '0;
            seen_wr   <= 1'b0;
        end else if (ram_wr_en) begin
            last_addr <= ram_wr_addr;
            seen_wr   <= 1'b1;
        end
    end

    AST_RAM_IN_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> (int'(ram_wr_addr) < COPY_BYTES)); // R2

    AST_BUSY_MID_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_wr_en && !load_done) |-> bus_busy); // R3

    AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_wr_en && ram_wr_addr != '0) |-> (seen_wr && ram_wr_addr == last_addr + RAM_AW'(1))); // R6

    AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (ram_wr_en && int'(ram_wr_addr) == COPY_BYTES - 1)); // R7

    AST_WRITE_ONLY_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_en |-> ($past(nv_rd_data) == '1)); // R8

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !nv_wr_en |=> $stable(wr_count)); // R10

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_wr_en && wr_count != '1) |=> (wr_count == $past(wr_count) + CNT_W'(1))); // R10

endmodule

bind nvcfg_loader nvcfg_loader_chk #(
    .RAM_AW    (RAM_AW),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .COPY_BYTES(PAGE_BYTES * COPY_PAGES)
) i_nvcfg_loader_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_busy   (bus_busy),
    .nv_rd_data (nv_rd_data),
    .nv_wr_en   (nv_wr_en),
    .ram_wr_en  (ram_wr_en),
    .ram_wr_addr(ram_wr_addr),
    .load_done  (load_done),
    .wr_count   (wr_count)
);

// File: tb/test_nvcfg_loader.sv
`timescale 1ns/1ps
module test_nvcfg_loader;
    localparam int RD_LAT = 2;
    localparam int BOOT   = 900;
    localparam int CNT_W  = 3;
    localparam int COPYN  = 224;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_good = 1'b0;
    logic        host_wr_en = 1'b0;
    logic        host_rd_en = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        bus_busy;
    logic        nv_rd_en;
    logic [15:0] nv_rd_addr;
    logic [7:0]  nv_rd_data;
    logic        nv_wr_en;
    logic [15:0] nv_wr_addr;
    logic [7:0]  nv_wr_data;
    logic        ram_wr_en;
    logic [7:0]  ram_wr_addr;
    logic [7:0]  ram_wr_data;
    logic        load_done;
    logic [CNT_W-1:0] wr_count;

    always #2.5 clk = ~clk;

    nvcfg_loader #(.RD_LAT(RD_LAT), .BOOT_CYCLES(BOOT), .CNT_W(CNT_W)) i_nvcfg_loader (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_busy(bus_busy),
        .nv_rd_en(nv_rd_en), .nv_rd_addr(nv_rd_addr), .nv_rd_data(nv_rd_data),
        .nv_wr_en(nv_wr_en), .nv_wr_addr(nv_wr_addr), .nv_wr_data(nv_wr_data),
        .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data),
        .load_done(load_done), .wr_count(wr_count)
    );

    // Behavioural model of the array and its read latency
    logic [7:0] mem [512];
    logic [7:0] pipe [RD_LAT];
    assign nv_rd_data = pipe[RD_LAT-1];

    always @(posedge clk) begin
        pipe[0] <= nv_rd_en ? mem[9'(nv_rd_addr - 16'hF800)] : 8'h00;
        for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
    end

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_wr_cyc = 0;
    bit first_of_copy = 1'b0;
    bit finished = 1'b0;
    int exp_ram [$];
    int exp_nv  [$];
    int rd_while_off = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference comparison on every clock
    always @(negedge clk) begin
        cyc++;
        if (!pwr_good && nv_rd_en) rd_while_off++;
        if (ram_wr_en) begin
            if (exp_ram.size() == 0) begin
                chk(1'b0, "R5", "unexpected ram write", {ram_wr_addr, ram_wr_data}, 0);
            end else begin
                int e;
                e = exp_ram.pop_front();
                chk({ram_wr_addr, ram_wr_data} == 16'(e), "R2", "ram write addr/data", {ram_wr_addr, ram_wr_data}, e);
                if (!first_of_copy)
                    chk(cyc - last_wr_cyc == RD_LAT + 1, "R6", "byte spacing", cyc - last_wr_cyc, RD_LAT + 1);
                first_of_copy = 1'b0;
                last_wr_cyc = cyc;
            end
        end
        if (load_done)
            chk(ram_wr_en && ram_wr_addr == 8'hDF && exp_ram.size() == 0, "R7", "done with last byte", ram_wr_addr, 8'hDF);
        if (nv_wr_en) begin
            if (exp_nv.size() == 0) begin
                chk(1'b0, "R8", "unexpected array write", {nv_wr_addr, nv_wr_data}, 0);
            end else begin
                int e;
                e = exp_nv.pop_front();
                chk({nv_wr_addr, nv_wr_data} == 24'(e), "R8", "array write addr/data", {nv_wr_addr, nv_wr_data}, e);
            end
            mem[9'(nv_wr_addr - 16'hF800)] = nv_wr_data;
        end
    end

    task automatic push_copy();
        for (int i = 0; i < COPYN; i++) exp_ram.push_back((i << 8) | int'(mem[i]));
        first_of_copy = 1'b1;
    endtask

    task automatic host_write(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        host_rd_en = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd_en = 1'b0;
        v = host_rdata;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run hung", cyc, 0);
        summary();
    end

    initial begin
        logic [7:0] rv;
        for (int i = 0; i < 512; i++) begin
            if (i < COPYN)      mem[i] = 8'((i * 13 + 7) & 8'hFF);
            else if (i < 256)   mem[i] = 8'hA5;
            else                mem[i] = 8'hFF;
        end
        mem[5]   = 8'hFF;
        mem[300] = 8'h42;
        for (int i = 0; i < RD_LAT; i++) pipe[i] = 8'h00;

        // R1: reset state
        repeat (5) @(negedge clk);
        chk(bus_busy && !nv_rd_en && !nv_wr_en && !ram_wr_en && !load_done && wr_count == 0,
            "R1", "reset outputs", {bus_busy, nv_rd_en, nv_wr_en, ram_wr_en, load_done}, 5'b10000);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(rd_while_off == 0 && bus_busy, "R1", "no read before power good", rd_while_off, 0);

        // R2/R3: power-up copy and boot budget
        push_copy();
        pwr_good = 1'b1;
        for (int n = 1; n <= BOOT + 2; n++) begin
            @(negedge clk);
            if (n == 50) begin
                host_wr_en = 1'b1; host_addr = 16'hF900; host_wdata = 8'h11;  // R5: ignored while busy
            end else begin
                host_wr_en = 1'b0;
            end
            if (n == BOOT - 1) chk(bus_busy == 1'b1, "R3", "busy before budget", bus_busy, 1);
            if (n == BOOT)     chk(bus_busy == 1'b0, "R3", "busy released at budget", bus_busy, 0);
        end
        chk(exp_ram.size() == 0, "R2", "boot copy complete", exp_ram.size(), 0);
        chk(wr_count == 0 && mem[256] == 8'hFF, "R5", "array write during boot ignored", wr_count, 0);
        host_read(16'h00D8, rv);
        chk(rv == 8'h00, "R7", "download bit reads 0", rv, 0);

        // R8/R10: accepted write to a blank byte
        exp_nv.push_back({16'hF900, 8'h3C});
        host_write(16'hF900, 8'h3C);
        repeat (8) @(negedge clk);
        chk(exp_nv.size() == 0 && wr_count == 1, "R8", "blank byte written", wr_count, 1);

        // R8/R9: rejected write, sticky error, clear on read
        host_write(16'hF92C, 8'h77);
        repeat (8) @(negedge clk);
        chk(mem[300] == 8'h42 && wr_count == 1, "R8", "non-blank rejected", mem[300], 8'h42);
        host_read(16'h00D9, rv);
        chk(rv == 8'h01, "R9", "error flag set", rv, 1);
        host_read(16'h00D9, rv);
        chk(rv == 8'h00, "R9", "error flag cleared by read", rv, 0);

        // Error again (byte now written), blank page-0 byte updated
        host_write(16'hF900, 8'h55);
        repeat (8) @(negedge clk);
        exp_nv.push_back({16'hF805, 8'h99});
        host_write(16'hF805, 8'h99);
        repeat (8) @(negedge clk);
        chk(wr_count == 2 && mem[5] == 8'h99, "R10", "count after two writes", wr_count, 2);

        // R4: bit 0 clear starts nothing
        host_write(16'h00D8, 8'hFE);
        repeat (10) @(negedge clk);
        chk(!bus_busy && exp_ram.size() == 0, "R4", "no copy on bit0=0", bus_busy, 0);

        // R11: other address ignored
        host_write(16'h0040, 8'hFF);
        repeat (10) @(negedge clk);
        chk(!bus_busy && wr_count == 2, "R11", "unmapped write ignored", bus_busy, 0);

        // R4/R5: user download, read of error flag during it is ignored
        push_copy();
        host_write(16'h00D8, 8'h01);
        chk(bus_busy == 1'b1, "R4", "user copy started", bus_busy, 1);
        repeat (100) @(negedge clk);
        host_read(16'h00D9, rv);
        while (!load_done) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_ram.size() == 0 && !bus_busy, "R4", "user copy complete", exp_ram.size(), 0);
        host_read(16'h00D9, rv);
        chk(rv == 8'h01, "R5", "error not cleared during busy", rv, 1);
        host_read(16'h00D9, rv);
        chk(rv == 8'h00, "R9", "error cleared after read", rv, 0);

        // R5: request held through the final capture cycle is dropped
        push_copy();
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = 16'h00D8; host_wdata = 8'h01;
        @(negedge clk);
        while (!load_done) @(negedge clk);
        host_wr_en = 1'b0;
        repeat (20) @(negedge clk);
        chk(exp_ram.size() == 0 && !bus_busy, "R5", "held request not re-armed", bus_busy, 0);

        // R10: saturation
        for (int k = 0; k < 6; k++) begin
            exp_nv.push_back({16'(16'hF800 + 400 + k), 8'(k + 1)});
            host_write(16'(16'hF800 + 400 + k), 8'(k + 1));
            repeat (8) @(negedge clk);
        end
        chk(wr_count == 3'd7 && exp_nv.size() == 0, "R10", "count saturates", wr_count, 7);

        summary();
    end
endmodule